// File: doc/BRIEF.md
# Element-Addressed Burst Read Adapter

This block lets a compute kernel read memory through an AXI4 read port without building bursts itself. The kernel posts read requests, each an element offset and an element count, on a valid/ready request stream. The block queues those requests and turns each one into one or more INCR bursts on the AR channel. It then hands the returned beats back to the kernel as an in-order valid/ready data stream. The kernel pops this stream when it needs a value, and a pop stalls until data is present.

A request becomes a byte address as the base address plus offset times element size. It is cut into bursts no longer than `MAX_BURST` beats. A burst is also shortened so that it never crosses a 4 KB page. An AR is issued only when the read-data buffer has room reserved for the whole burst, so RREADY never needs to drop. The kernel can queue several requests while memory is still busy. With requests queued ahead, data arrives at one element per cycle. A response code other than OKAY raises a sticky error flag, and the data is still delivered.

Back-pressure rules: a request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low while the request queue is full. An output element is consumed on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The AR channel follows AXI: address and length stay stable until accepted.

Top module: `burst_rd_adapter`

## Requirements
- R1: During and right after reset, `ar_valid` and `out_valid` are low, `resp_err` is low and `req_ready` is high.
- R2: The first burst of a request carries the address `base_addr + offset * (DATA_W/8)`. `ar_burst` is 2'b01 (INCR), `ar_size` is log2 of the element byte count (2 for 32-bit elements), and `ar_id` is the fixed `ID_VALUE`.
- R3: A request is split into consecutive bursts of at most `MAX_BURST` beats. `ar_len` is the beat count minus one, the beat counts add up to the element count, and AR address and length stay stable while `ar_valid` waits for `ar_ready`.
- R4: No burst crosses a 4 KB boundary. A burst that would cross one ends at the boundary, and the next burst starts exactly on it.
- R5: Output elements come out in the order the requests were posted. Within a request they come out in ascending element order, each holding the memory word at its address.
- R6: `out_data` holds its value while `out_valid` is high and `out_ready` is low. No element is lost or duplicated across such a stall.
- R7: When requests are queued ahead and memory returns beats back to back, 64 elements from four 16-element requests leave on 64 consecutive cycles.
- R8: An AR is issued only if the read buffer (`BUF_DEPTH` entries) has room for the whole burst, counting beats still in flight. With the consumer stalled, no more than `BUF_DEPTH` beats are requested, and the buffer never overflows.
- R9: A beat with `r_resp` other than 2'b00 sets `resp_err`, which stays set until reset. That beat's data is still delivered.
- R10: A request with count 0 is accepted and produces no burst and no data.
- R11: The request queue holds `REQ_DEPTH` requests beside the one being split, so up to `REQ_DEPTH+1` requests are accepted while the AR channel is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | ADDR_W | Byte address of element 0 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request queue has room |
| req_offset | input | OFF_W | First element index of the request |
| req_count | input | CNT_W | Number of elements requested |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_id | output | ID_W | Fixed transaction ID |
| ar_addr | output | ADDR_W | Burst start byte address |
| ar_len | output | 8 | Beats in burst minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, always INCR |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data accepted (held high) |
| r_data | input | DATA_W | Read data beat |
| r_resp | input | 2 | Read response code |
| out_valid | output | 1 | Element available to the kernel |
| out_ready | input | 1 | Kernel pops the element |
| out_data | output | DATA_W | Element value |
| resp_err | output | 1 | Sticky flag for a non-OKAY response |

## Verification
The bench uses the defaults: 32-bit elements, `MAX_BURST` of 16, `BUF_DEPTH` of 32 and `REQ_DEPTH` of 4. With these values a 4 KB page is only 1024 elements, so page crossings can be reached with small offsets. The credit limit is reached after two full bursts, which shows the AR stall while the consumer is held off. The request queue fills after five posts, so a blocked AR channel exposes the queue limit within a few cycles. A memory model in the bench returns a word computed from each beat's address, which lets every delivered element be checked against its offset.

// File: rtl/bra_pkg.sv
`timescale 1ns/1ps
package bra_pkg;
  localparam logic [1:0] AXI_BURST_INCR = 2'b01;
  localparam logic [1:0] AXI_RESP_OKAY  = 2'b00;
  localparam int unsigned PAGE_BYTES    = 4096;
  localparam int unsigned PAGE_BITS     = 12;
endpackage

// File: rtl/bra_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO; DEPTH must be a power of two, at least 2.
module bra_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/bra_splitter.sv
`timescale 1ns/1ps
// Turns queued element requests into page-safe, length-capped AR bursts,
// gated by a credit count of free read-buffer entries.
module bra_splitter #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 24,
  parameter int CNT_W     = 16,
  parameter int BYTES     = 4,
  parameter int MAX_BURST = 16,
  parameter int BUF_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              q_empty,
  input  logic [OFF_W-1:0]  q_off,
  input  logic [CNT_W-1:0]  q_cnt,
  output logic              q_pop,
  input  logic              beat_taken,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len
);
  import bra_pkg::*;

  localparam int SL  = $clog2(BYTES);
  localparam int PB  = PAGE_BYTES / BYTES;
  localparam int CRW = $clog2(BUF_DEPTH) + 1;
  localparam int LW  = CNT_W + 1;

  logic              busy;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  remain;
  logic [CRW-1:0]    space;
  logic [LW-1:0]     to_page, cap, blen;
  logic              fire, done;
  logic [ADDR_W-1:0] load_addr;

  always_comb begin
    to_page = LW'(PB) - LW'(addr[PAGE_BITS-1:SL]);
    cap     = (LW'(MAX_BURST) < to_page) ? LW'(MAX_BURST) : to_page;
    blen    = (LW'(remain) < cap) ? LW'(remain) : cap;
  end

  assign ar_valid  = busy && (LW'(space) >= blen);
  assign fire      = ar_valid && ar_ready;
  assign done      = fire && (LW'(remain) == blen);
  assign q_pop     = (!busy || done) && !q_empty;
  assign ar_addr   = addr;
  assign ar_len    = 8'(blen - 1'b1);
  assign load_addr = base_addr + (ADDR_W'(q_off) << SL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr   <= '0;
      remain <= '0;
      space  <= CRW'(BUF_DEPTH);
    end else begin
      if (q_pop) begin
        busy   <= (q_cnt != '0);
        addr   <= load_addr;
        remain <= q_cnt;
      end else if (fire) begin
        addr   <= addr + (ADDR_W'(blen) << SL);
        remain <= remain - CNT_W'(blen);
        if (done) busy <= 1'b0;
      end
      space <= space - (fire ? CRW'(blen) : '0) + (beat_taken ? CRW'(1) : '0);
    end
  end
endmodule

// File: rtl/burst_rd_adapter.sv
`timescale 1ns/1ps
module burst_rd_adapter #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 24,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 16,
  parameter int REQ_DEPTH = 4,
  parameter int BUF_DEPTH = 32,
  parameter int ID_W      = 4,
  parameter int ID_VALUE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [CNT_W-1:0]  req_count,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ID_W-1:0]   ar_id,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              resp_err
);
  import bra_pkg::*;

  localparam int ELEM_BYTES = DATA_W / 8;
  localparam int SIZE_CODE  = $clog2(ELEM_BYTES);
  localparam int RQ_W       = OFF_W + CNT_W;

  logic              rq_full, rq_empty, rq_pop;
  logic [RQ_W-1:0]   rq_head;
  logic              dq_full, dq_empty, dq_pop;

  assign req_ready = !rq_full;

  bra_fifo #(.W(RQ_W), .DEPTH(REQ_DEPTH)) u_reqq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_valid),
    .wr_data ({req_offset, req_count}),
    .rd_en   (rq_pop),
    .rd_data (rq_head),
    .full    (rq_full),
    .empty   (rq_empty)
  );

  bra_splitter #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .BYTES(ELEM_BYTES),
    .MAX_BURST(MAX_BURST), .BUF_DEPTH(BUF_DEPTH)
  ) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_addr  (base_addr),
    .q_empty    (rq_empty),
    .q_off      (rq_head[RQ_W-1:CNT_W]),
    .q_cnt      (rq_head[CNT_W-1:0]),
    .q_pop      (rq_pop),
    .beat_taken (dq_pop),
    .ar_valid   (ar_valid),
    .ar_ready   (ar_ready),
    .ar_addr    (ar_addr),
    .ar_len     (ar_len)
  );

  assign ar_id    = ID_W'(ID_VALUE);
  assign ar_size  = 3'(SIZE_CODE);
  assign ar_burst = AXI_BURST_INCR;
  assign r_ready  = 1'b1;

  assign out_valid = !dq_empty;
  assign dq_pop    = out_valid && out_ready;

  bra_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_dataq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (r_valid && !dq_full),
    .wr_data (r_data),
    .rd_en   (dq_pop),
    .rd_data (out_data),
    .full    (dq_full),
    .empty   (dq_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) resp_err <= 1'b0;
    else if (r_valid && (r_resp != AXI_RESP_OKAY)) resp_err <= 1'b1;
  end
endmodule

// File: rtl/bra_checker.sv
`timescale 1ns/1ps
module bra_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BYTES     = 4,
  parameter int MAX_BURST = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic              r_valid,
  input logic              buf_full,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              resp_err
);
  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len));

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (32'(ar_len) < 32'(MAX_BURST)));

  assert_page_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (32'(ar_addr[11:0]) + (32'(ar_len) + 32'd1) * 32'(BYTES)) <= 32'd4096);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !buf_full);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |=> resp_err);
endmodule

bind burst_rd_adapter bra_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(ELEM_BYTES), .MAX_BURST(MAX_BURST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ar_valid  (ar_valid),
  .ar_ready  (ar_ready),
  .ar_addr   (ar_addr),
  .ar_len    (ar_len),
  .r_valid   (r_valid),
  .buf_full  (dq_full),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .resp_err  (resp_err)
);

// File: tb/sim_burst_rd_adapter.sv
`timescale 1ns/1ps
module sim_burst_rd_adapter;
  localparam logic [31:0] BASE = 32'h1000_0000;

  typedef struct packed {
    logic [23:0] off;
    logic [15:0] cnt;
    logic [7:0]  nb;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{24'd0,    16'd16, 8'd1},
    '{24'd40,   16'd40, 8'd3},
    '{24'd1020, 16'd10, 8'd2},
    '{24'd500,  16'd1,  8'd1},
    '{24'd7,    16'd17, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_offset = '0;
  logic [15:0] req_count = '0;
  logic        ar_valid, ar_ready = 1'b0;
  logic [3:0]  ar_id;
  logic [31:0] ar_addr;
  logic [7:0]  ar_len;
  logic [2:0]  ar_size;
  logic [1:0]  ar_burst;
  logic        r_valid = 1'b0, r_ready;
  logic [31:0] r_data = '0;
  logic [1:0]  r_resp = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_data;
  logic        resp_err;

  always #4 clk = ~clk;

  burst_rd_adapter u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(BASE),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_count(req_count),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .resp_err(resp_err)
  );

  int          checks = 0, fails = 0, cyc = 0;
  logic [31:0] q_addr [256];
  logic [7:0]  q_len  [256];
  int          q_wr = 0, q_rd = 0, beat_i = 0;
  logic [31:0] got [1024];
  int          got_cyc [1024];
  int          got_n = 0;
  bit          cons_en = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  function automatic logic [31:0] word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: answers AR bursts with back-to-back beats
  initial forever begin
    @(negedge clk);
    if (r_valid && r_ready) begin
      if (beat_i == int'(q_len[q_rd])) begin q_rd = q_rd + 1; beat_i = 0; end
      else beat_i = beat_i + 1;
    end
    if (q_rd != q_wr) begin
      r_valid = 1'b1;
      r_data  = word(q_addr[q_rd] + 32'(beat_i * 4));
      r_resp  = (q_addr[q_rd] == err_addr && beat_i == 0) ? 2'b10 : 2'b00;
    end else begin
      r_valid = 1'b0;
      r_resp  = 2'b00;
    end
    if (ar_valid && ar_ready) begin
      q_addr[q_wr] = ar_addr;
      q_len[q_wr]  = ar_len;
      q_wr = q_wr + 1;
    end
  end

  // kernel-side consumer
  initial forever begin
    @(negedge clk);
    out_ready = cons_en;
    if (out_valid && out_ready) begin
      got[got_n]     = out_data;
      got_cyc[got_n] = cyc;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_data(input int g0, input int off, input int cnt, input string req);
    int bad = 0;
    logic [31:0] a = '0, e = '0;
    for (int i = 0; i < cnt; i++) begin
      if (got[g0+i] !== word(BASE + 32'((off + i) * 4))) begin
        if (bad == 0) begin a = got[g0+i]; e = word(BASE + 32'((off + i) * 4)); end
        bad++;
      end
    end
    chk(bad == 0, req, a, e);
  endtask

  task automatic post(input int off, input int cnt);
    @(posedge clk); #1;
    req_valid = 1'b1; req_offset = 24'(off); req_count = 16'(cnt);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic try_post(input int off, input int cnt, output bit acc);
    @(posedge clk); #1;
    req_valid = 1'b1; req_offset = 24'(off); req_count = 16'(cnt);
    @(negedge clk); acc = req_ready;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_items(input int n);
    int t = 0;
    while (got_n < n && t < 3000) begin @(posedge clk); t++; end
    repeat (4) @(posedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int a0, g0, s;
    bit acc;
    int nacc;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(ar_valid == 1'b0, "R1 ar_valid", 32'(ar_valid), 0);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(resp_err == 1'b0, "R1 resp_err", 32'(resp_err), 0);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ar_valid == 1'b0 && out_valid == 1'b0, "R1 after release", 32'({ar_valid, out_valid}), 0);

    // table of requests walked in one loop
    cons_en = 1'b1;
    @(posedge clk); #1 ar_ready = 1'b1;
    for (int v = 0; v < 5; v++) begin
      a0 = q_wr; g0 = got_n;
      post(int'(VECS[v].off), int'(VECS[v].cnt));
      wait_items(g0 + int'(VECS[v].cnt));
      chk(q_wr - a0 == int'(VECS[v].nb), "R3 burst count", 32'(q_wr - a0), 32'(VECS[v].nb));
      chk(q_addr[a0] == BASE + 32'(int'(VECS[v].off) * 4), "R2 first address",
          q_addr[a0], BASE + 32'(int'(VECS[v].off) * 4));
      s = 0;
      for (int j = a0; j < q_wr; j++) s += int'(q_len[j]) + 1;
      chk(s == int'(VECS[v].cnt), "R3 beat total", 32'(s), 32'(VECS[v].cnt));
      check_data(g0, int'(VECS[v].off), int'(VECS[v].cnt), "R5 data order");
    end

    // R4: page crossing at byte 0x2000
    a0 = q_wr; g0 = got_n;
    post(2044, 8);
    wait_items(g0 + 8);
    chk(q_wr - a0 == 2, "R4 split count", 32'(q_wr - a0), 2);
    chk(q_len[a0] == 8'd3, "R4 first len", 32'(q_len[a0]), 3);
    chk(q_addr[a0+1] == BASE + 32'h2000, "R4 second addr", q_addr[a0+1], BASE + 32'h2000);
    chk(q_len[a0+1] == 8'd3, "R4 second len", 32'(q_len[a0+1]), 3);
    check_data(g0, 2044, 8, "R4 data");

    // R11 queue depth with AR blocked, R2 fields
    @(posedge clk); #1 ar_ready = 1'b0;
    g0 = got_n; nacc = 0;
    for (int k = 0; k < 7; k++) begin
      try_post(600 + nacc, 1, acc);
      if (acc) nacc++;
    end
    chk(nacc == 5, "R11 accepted", 32'(nacc), 5);
    @(negedge clk);
    chk(ar_valid == 1'b1 && ar_addr == BASE + 32'(600 * 4) && ar_len == 8'd0,
        "R2 pending AR", ar_addr, BASE + 32'(600 * 4));
    chk(ar_size == 3'd2 && ar_burst == 2'b01 && ar_id == 4'd0, "R2 AR fields",
        32'({ar_size, ar_burst, ar_id}), 32'({3'd2, 2'b01, 4'd0}));
    @(posedge clk); #1 ar_ready = 1'b1;
    wait_items(g0 + 5);
    check_data(g0, 600, 5, "R11 data");

    // R7: four queued requests stream without gaps
    @(posedge clk); #1 ar_ready = 1'b0;
    g0 = got_n;
    for (int k = 0; k < 4; k++) post(k * 128, 16);
    @(posedge clk); #1 ar_ready = 1'b1;
    wait_items(g0 + 64);
    chk(got_cyc[g0+63] - got_cyc[g0] == 63, "R7 gapless span",
        32'(got_cyc[g0+63] - got_cyc[g0]), 63);
    for (int k = 0; k < 4; k++) check_data(g0 + 16 * k, k * 128, 16, "R7 data");

    // R8 credit limit and R6 hold with consumer stalled
    cons_en = 1'b0;
    a0 = q_wr; g0 = got_n;
    post(0, 48);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(q_wr - a0 == 2, "R8 bursts while stalled", 32'(q_wr - a0), 2);
    chk(out_valid == 1'b1 && out_data == word(BASE), "R6 head shown", out_data, word(BASE));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == word(BASE), "R6 head held", out_data, word(BASE));
    cons_en = 1'b1;
    wait_items(g0 + 48);
    chk(q_wr - a0 == 3, "R8 bursts after drain", 32'(q_wr - a0), 3);
    check_data(g0, 0, 48, "R6 no loss");

    // R9 sticky error
    chk(resp_err == 1'b0, "R9 clear before", 32'(resp_err), 0);
    err_addr = BASE + 32'h400;
    g0 = got_n;
    post(256, 4);
    wait_items(g0 + 4);
    chk(resp_err == 1'b1, "R9 set", 32'(resp_err), 1);
    check_data(g0, 256, 4, "R9 data kept");
    g0 = got_n;
    post(0, 2);
    wait_items(g0 + 2);
    chk(resp_err == 1'b1, "R9 sticky", 32'(resp_err), 1);

    // R10 zero-count request
    a0 = q_wr; g0 = got_n;
    post(5, 0);
    post(9, 1);
    wait_items(g0 + 1);
    repeat (20) @(posedge clk);
    chk(q_wr - a0 == 1, "R10 bursts", 32'(q_wr - a0), 1);
    chk(got_n == g0 + 1, "R10 elements", 32'(got_n - g0), 1);
    chk(got[g0] == word(BASE + 32'd36), "R10 value", got[g0], word(BASE + 32'd36));

    summary();
  end
endmodule